// File: doc/BRIEF.md
# Pair-Threshold Detector (OR-AND-OR Network)

This block raises a single output whenever two or more bits of an N-bit input vector are set. It is purely combinational. It is not built as an adder with a comparator, and not as a flat sum of products. Instead it is a three-level OR-AND-OR network.

Every input position gets its own distinct code word of M = ceil(log2 N) bits. For each code bit (a "column"), the inputs fall into two disjoint groups: the inputs whose code bit is 0 and the inputs whose code bit is 1. One OR gate collects each group, and one AND gate combines the two ORs of that column. An output OR then gathers the M column ANDs.

Any two distinct inputs have codes that differ in at least one column. That column's AND fires when both of those inputs are set. A lone set input can only ever reach one side of each column, so it never fires an AND. The gate count therefore grows with log2 N rather than with N.

The code assignment is a parameter. The choices are plain binary index or reflected-binary (Gray) index. Both give distinct codes, so both yield the same function. N need not be a power of two.

Top module: `tnw_top`

## Requirements
- R1: `thr_out` is 1 exactly when the population count of `x_in` is 2 or more, in the same cycle the input is applied (no register on the path).
- R2: With `x_in` all zeros, `thr_out` is 0.
- R3: With exactly one bit of `x_in` set, for every bit position, `thr_out` is 0. Inside the network, such an input drives exactly one of the two OR sums in every column.
- R4: With exactly two bits of `x_in` set, for every unordered pair of positions, `thr_out` is 1.
- R5: With the code style parameter set to Gray (code of index i is i XOR (i >> 1)), the function of R1 is unchanged.
- R6: When N is not a power of two (for example N = 6, using M = 3 columns), the function of R1 is unchanged.
- R7: Starting from one set bit, setting a second bit raises `thr_out` to 1. Clearing that second bit returns it to 0, and clearing the first bit keeps it at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | N | Input vector whose set bits are counted against the threshold of two |
| thr_out | output | 1 | High when at least two bits of `x_in` are set |

## Verification
Every result here is due in the same cycle as its stimulus, because no register lies between `x_in` and `thr_out`. The bench changes the inputs at the falling clock edge and reads the output 2 ns later, so every read lands well after the inputs settle and well before the next rising edge. Each pattern gets its own clock cycle, so a stale value from the previous pattern cannot be mistaken for the current one.

// File: rtl/tnw_pkg.sv
package tnw_pkg;

  // How each input index is mapped to its column code word.
  typedef enum logic [0:0] {
    CODE_BINARY = 1'b0,
    CODE_GRAY   = 1'b1
  } code_style_e;

  // Number of columns needed so that every index in [0, n) has a distinct code.
  function automatic int col_count(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Bit 'pos' of the code word given to input 'idx' under style 's'.
  function automatic logic code_bit(input int idx, input int pos, input code_style_e s);
    int word;
    word = (s == CODE_GRAY) ? (idx ^ (idx >> 1)) : idx;
    return ((word >> pos) & 1) != 0;
  endfunction

endpackage

// File: rtl/tnw_column.sv
// One column of the decomposition: two disjoint OR sums over the inputs
// split by one code bit, and the AND of those two sums.
module tnw_column
  import tnw_pkg::*;
#(
  parameter int          N     = 16,
  parameter int          BIT   = 0,
  parameter code_style_e STYLE = CODE_BINARY
) (
  input  logic [N-1:0] x_in,
  output logic         lo_sum,
  output logic         hi_sum,
  output logic         pair_hit
);

  // Membership of each input in the "code bit = 1" group, fixed at elaboration.
  logic [N-1:0] hi_sel;

  for (genvar i = 0; i < N; i++) begin : g_sel
    assign hi_sel[i] = code_bit(i, BIT, STYLE);
  end

  // Level 1: the two input OR gates of this column.
  assign lo_sum   = |(x_in & ~hi_sel);
  assign hi_sum   = |(x_in &  hi_sel);

  // Level 2: the column AND gate.
  assign pair_hit = lo_sum & hi_sum;

endmodule

// File: rtl/tnw_top.sv
// Pair-threshold detector: output high when two or more inputs are set.
module tnw_top
  import tnw_pkg::*;
#(
  parameter int          N     = 16,
  parameter code_style_e STYLE = CODE_BINARY
) (
  input  logic [N-1:0] x_in,
  output logic         thr_out
);

  localparam int M = col_count(N);

  logic [M-1:0] lo_sum;
  logic [M-1:0] hi_sum;
  logic [M-1:0] col_and;

  for (genvar j = 0; j < M; j++) begin : g_col
    tnw_column #(
      .N    (N),
      .BIT  (j),
      .STYLE(STYLE)
    ) u_col (
      .x_in    (x_in),
      .lo_sum  (lo_sum[j]),
      .hi_sum  (hi_sum[j]),
      .pair_hit(col_and[j])
    );
  end

  // Level 3: output OR over all column AND gates.
  assign thr_out = |col_and;

endmodule

// File: rtl/tnw_top_chk.sv
// Property checker attached to every tnw_top instance.
module tnw_top_chk #(
  parameter int N = 16,
  parameter int M = 4
) (
  input logic [N-1:0] x_in,
  input logic         thr_out,
  input logic [M-1:0] lo_sum,
  input logic [M-1:0] hi_sum,
  input logic [M-1:0] col_and
);

  always_comb begin
    if (!$isunknown(x_in)) begin
      // R1: output agrees with a population count against two
      assert_thr_match_R1: assert (thr_out == ($countones(x_in) >= 2))
        else $error("thr_out disagrees with popcount");

      // R2: all-zero input gives a quiet network
      if (x_in == '0) begin
        assert_zero_quiet_R2: assert (!thr_out && (col_and == '0))
          else $error("activity on all-zero input");
      end

      // R3: a lone set input lights exactly one side of each column
      if ($countones(x_in) == 1) begin
        assert_single_quiet_R3: assert (!thr_out)
          else $error("lone input raised output");
        assert_single_split_R3: assert (((lo_sum ^ hi_sum) == '1) && ((lo_sum & hi_sum) == '0))
          else $error("column sums not disjoint for lone input");
      end

      // R4: no column AND fires unless at least two inputs are set
      assert_col_needs_pair_R4: assert ((col_and == '0) || ($countones(x_in) >= 2))
        else $error("column AND fired below threshold");
    end
  end

endmodule

bind tnw_top tnw_top_chk #(
  .N(N),
  .M(M)
) u_chk (
  .x_in   (x_in),
  .thr_out(thr_out),
  .lo_sum (lo_sum),
  .hi_sum (hi_sum),
  .col_and(col_and)
);

// File: tb/tnw_top_test.sv
module tnw_top_test;
  import tnw_pkg::*;

  localparam int NA = 10;  // binary codes, exhaustive
  localparam int NB = 16;  // Gray codes, weight sweeps plus random
  localparam int NC = 6;   // width that is not a power of two

  logic clk;
  logic rst_n;
  logic [NA-1:0] xa;
  logic [NB-1:0] xb;
  logic [NC-1:0] xc;
  logic ya, yb, yc;

  int n_chk;
  int n_err;
  bit done;

  tnw_top #(.N(NA), .STYLE(CODE_BINARY)) uut      (.x_in(xa), .thr_out(ya));
  tnw_top #(.N(NB), .STYLE(CODE_GRAY))   uut_gray (.x_in(xb), .thr_out(yb));
  tnw_top #(.N(NC), .STYLE(CODE_BINARY)) uut_six  (.x_in(xc), .thr_out(yc));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // Apply one pattern to all instances at the falling edge; sample 2 ns later.
  task automatic drive(input logic [NA-1:0] a, input logic [NB-1:0] b, input logic [NC-1:0] c);
    @(negedge clk);
    xa = a;
    xb = b;
    xc = c;
    #2;
  endtask

  task automatic t_idle_r2;
    drive('0, '0, '0);
    check("R2", "binary zero", ya, 1'b0);
    check("R2", "gray zero",   yb, 1'b0);
    check("R2", "six zero",    yc, 1'b0);
  endtask

  task automatic t_exhaustive_r1;
    for (int p = 0; p < (1 << NA); p++) begin
      drive(NA'(p), '0, '0);
      check("R1", $sformatf("pattern %0h", p), ya, $countones(NA'(p)) >= 2);
    end
  endtask

  task automatic t_singles_r3;
    for (int i = 0; i < NB; i++) begin
      drive((i < NA) ? NA'(1) << i : '0, NB'(1) << i, (i < NC) ? NC'(1) << i : '0);
      if (i < NA) check("R3", $sformatf("binary lone %0d", i), ya, 1'b0);
      check("R3", $sformatf("gray lone %0d", i), yb, 1'b0);
      if (i < NC) check("R3", $sformatf("six lone %0d", i), yc, 1'b0);
    end
  endtask

  task automatic t_pairs_r4;
    for (int i = 0; i < NB; i++) begin
      for (int k = i + 1; k < NB; k++) begin
        drive((k < NA) ? (NA'(1) << i) | (NA'(1) << k) : '0,
              (NB'(1) << i) | (NB'(1) << k),
              (k < NC) ? (NC'(1) << i) | (NC'(1) << k) : '0);
        if (k < NA) check("R4", $sformatf("binary pair %0d,%0d", i, k), ya, 1'b1);
        check("R4", $sformatf("gray pair %0d,%0d", i, k), yb, 1'b1);
        if (k < NC) check("R4", $sformatf("six pair %0d,%0d", i, k), yc, 1'b1);
      end
    end
  endtask

  task automatic t_gray_random_r5;
    for (int r = 0; r < 3000; r++) begin
      logic [NB-1:0] v;
      v = NB'($urandom);
      if (r % 3 == 1) v = v & NB'($urandom);
      if (r % 3 == 2) v = v & NB'($urandom) & NB'($urandom);
      drive('0, v, '0);
      check("R5", $sformatf("gray pattern %0h", v), yb, $countones(v) >= 2);
    end
  endtask

  task automatic t_odd_width_r6;
    for (int p = 0; p < (1 << NC); p++) begin
      drive('0, '0, NC'(p));
      check("R6", $sformatf("six pattern %0h", p), yc, $countones(NC'(p)) >= 2);
    end
  endtask

  task automatic t_threshold_walk_r7;
    for (int i = 0; i < NA; i++) begin
      int k;
      k = (i + 3) % NA;
      drive(NA'(1) << i, '0, '0);
      check("R7", $sformatf("one set %0d", i), ya, 1'b0);
      drive((NA'(1) << i) | (NA'(1) << k), '0, '0);
      check("R7", $sformatf("add %0d", k), ya, 1'b1);
      drive(NA'(1) << i, '0, '0);
      check("R7", $sformatf("drop %0d", k), ya, 1'b0);
      drive('0, '0, '0);
      check("R7", $sformatf("drop %0d", i), ya, 1'b0);
    end
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    done  = 1'b0;
    xa = '0;
    xb = '0;
    xc = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_idle_r2();
    t_exhaustive_r1();
    t_singles_r3();
    t_pairs_r4();
    t_gray_random_r5();
    t_odd_width_r6();
    t_threshold_walk_r7();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog run did not complete actual timeout expected done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule